// File: doc/BRIEF.md
# Stream-to-Memory Descriptor Scatter Engine

This engine takes one packet at a time from a byte-wide input stream and spreads its bytes over a linked chain of buffer descriptors held in memory. Each descriptor is fetched as four 32-bit words, filled with packet bytes, and then marked as owned by software through a written-back status word. The status word records how many bytes were stored and whether this descriptor opened or closed the packet. The descriptor that receives the final byte also gets five application words. These words come from a separate side stream that software-facing logic delivers ahead of the packet.

A host loads the head and tail descriptor addresses and pulses `kick` while `run` is high. The engine walks the chain until it handles the tail descriptor, where it stops in an idle state. It stops in a halted state if it meets a descriptor that is still marked complete from earlier use. Memory is reached through one simple request/acknowledge port that carries word reads, word writes and single-byte writes.

States: `ST_HALT` (reset state; `kick` with `run` goes to `ST_FETCH`), `ST_FETCH` (four word reads; the last acknowledged read goes to `ST_EVAL`), `ST_EVAL` (an owned descriptor goes to `ST_HALT`, zero capacity goes to `ST_STAT`, otherwise `ST_DATA`), `ST_DATA` (an accepted byte goes to `ST_STORE`), `ST_STORE` (after the byte write: a final byte goes to `ST_APP`, a full descriptor goes to `ST_STAT`, otherwise back to `ST_DATA`), `ST_APP` (five application word writes, then `ST_STAT`), `ST_STAT` (status write, then `ST_NEXT`), `ST_NEXT` (tail reached goes to `ST_IDLE`, otherwise `ST_FETCH` at the next pointer), `ST_IDLE` (`kick` with `run` goes to `ST_FETCH`).

Top module: `s2m_scatter`

## Requirements
- R1: The descriptor layout is: next pointer at byte offset 0, buffer address at 4, control word at 8, status word at 12, application words at 16 to 32. Control bits 22:0 give the capacity. Byte i of a descriptor's share of the packet goes to buffer address + i. A descriptor takes bytes until its capacity is used or the packet ends, whichever comes first.
- R2: If the fetched status word has bit 31 set, the engine writes nothing to that descriptor and raises `halted`. `s_ready` then stays low until a new `kick`.
- R3: Status bit 27 is set only in the first descriptor that stores a byte of a packet.
- R4: Status bit 26 is set in the descriptor that stores the final byte (`s_last`). Only that descriptor has the five stored application words written to its offsets 16, 20, 24, 28 and 32, in capture order.
- R5: Every written-back status word has bit 31 set. Its bits 22:0 hold the number of bytes stored in that descriptor, and all other bits are zero.
- R6: `pkt_done` is a one-cycle pulse, given once per packet after the final descriptor's status write is acknowledged.
- R7: After each status write the engine follows the next pointer. If the descriptor just handled was at the `tail_ptr` address, it enters idle with `idle` high and fetches nothing more. `idle` and `halted` are never high together.
- R8: A side-stream packet of exactly five words (ending with `c_last`) replaces the stored application words. A packet of any other length leaves them unchanged and raises `c_err` for one cycle, in the cycle after its last word.
- R9: `s_ready` is low whenever `run` is low, and in the halted and idle states.
- R10: While `mem_req` is high and not yet acknowledged, the request and its address and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel running; gates `s_ready` and `kick` |
| kick | input | 1 | Start the walk at `head_ptr` (from halted or idle) |
| head_ptr | input | AW | First descriptor address |
| tail_ptr | input | AW | Last descriptor address of the chain |
| s_valid | input | 1 | Data byte valid |
| s_ready | output | 1 | Data byte accepted when high with `s_valid` |
| s_data | input | 8 | Data byte |
| s_last | input | 1 | Final byte of the packet |
| c_valid | input | 1 | Side-stream word valid (always accepted) |
| c_data | input | 32 | Side-stream word |
| c_last | input | 1 | Final word of a side-stream packet |
| c_err | output | 1 | One-cycle pulse: side-stream packet had the wrong length |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = word read |
| mem_byte | output | 1 | Write is a single byte in `mem_wdata[7:0]` |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| pkt_done | output | 1 | One-cycle packet completion pulse |
| halted | output | 1 | Stopped at reset or on an owned descriptor |
| idle | output | 1 | Stopped after the tail descriptor |

## Verification
A wrong fill count or flag register shows up in the status word, at the status write that closes the descriptor. At the latest, that is a few cycles after the packet's last byte. A lost start-of-packet flag or a stale end flag surfaces on the next packet's status. A wrong chain position shows as status writes to unexpected addresses, or as `idle` rising early or late. A side-stream counting error shows as a `c_err` pulse on a good packet, or as wrong application words in memory at the end of the next packet. A broken stall hold shows at the port within one stalled cycle.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
    localparam int WORD_W   = 32;
    localparam int OFS_STAT = 12;
    localparam int OFS_APP  = 16;
    localparam int BIT_DONE = 31;
    localparam int BIT_SOP  = 27;
    localparam int BIT_EOP  = 26;

    typedef enum logic [3:0] {
        ST_HALT,
        ST_FETCH,
        ST_EVAL,
        ST_DATA,
        ST_STORE,
        ST_APP,
        ST_STAT,
        ST_NEXT,
        ST_IDLE
    } s2m_state_e;
endpackage

// File: rtl/s2m_app_capture.sv
module s2m_app_capture #(
    parameter int WORDS = 5,
    localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int CW = $clog2(WORDS + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          c_valid,
    input  logic [31:0]   c_data,
    input  logic          c_last,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_word,
    output logic          c_err
);
    logic [31:0]   staged [WORDS];
    logic [31:0]   held   [WORDS];
    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen  <= '0;
            c_err <= 1'b0;
            for (int i = 0; i < WORDS; i++) begin
                staged[i] <= '0;
                held[i]   <= '0;
            end
        end else begin
            c_err <= 1'b0;
            if (c_valid) begin
                if (seen < CW'(WORDS))
                    staged[IW'(seen)] <= c_data;
                if (c_last) begin
                    seen <= '0;
                    if (seen == CW'(WORDS - 1)) begin
                        for (int i = 0; i < WORDS; i++)
                            held[i] <= (i == WORDS - 1) ? c_data : staged[i];
                    end else begin
                        c_err <= 1'b1;
                    end
                end else if (seen < CW'(WORDS)) begin
                    seen <= seen + CW'(1);
                end
            end
        end
    end

    assign rd_word = held[rd_idx];
endmodule

// File: rtl/s2m_fill_counter.sv
module s2m_fill_counter #(
    parameter int LW = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [LW-1:0] cap,
    output logic [LW-1:0] count,
    output logic          last_slot
);
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + LW'(1);
    end

    assign last_slot = (count + LW'(1)) == cap;
endmodule

// File: rtl/s2m_scatter.sv
module s2m_scatter
    import s2m_pkg::*;
#(
    parameter int AW        = 32,
    parameter int LW        = 23,
    parameter int APP_WORDS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          kick,
    input  logic [AW-1:0] head_ptr,
    input  logic [AW-1:0] tail_ptr,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic [7:0]    s_data,
    input  logic          s_last,
    input  logic          c_valid,
    input  logic [31:0]   c_data,
    input  logic          c_last,
    output logic          c_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_byte,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          pkt_done,
    output logic          halted,
    output logic          idle
);
    localparam int IDXW = (APP_WORDS > 1) ? $clog2(APP_WORDS) : 1;
    localparam int WIW  = (IDXW > 2) ? IDXW : 2;

    s2m_state_e state, state_nx;

    logic [AW-1:0]  cur, nxt_ptr, buf_ptr;
    logic [LW-1:0]  cap, count;
    logic           owned, last_slot;
    logic [WIW-1:0] widx;
    logic [7:0]     byte_q;
    logic           last_q, sof_pend, sop_here, eop_q;
    logic [31:0]    app_word, stat_word;
    logic           start_ok, accept, unused_bits;

    assign start_ok = kick && run;
    assign accept   = s_valid && s_ready;
    assign unused_bits = ^{mem_rdata[30:LW], head_ptr[0]};

    s2m_app_capture #(.WORDS(APP_WORDS)) u_app (
        .clk(clk), .rst_n(rst_n), .c_valid(c_valid), .c_data(c_data),
        .c_last(c_last), .rd_idx(IDXW'(widx)), .rd_word(app_word), .c_err(c_err)
    );

    s2m_fill_counter #(.LW(LW)) u_fill (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_EVAL),
        .inc(state == ST_STORE && mem_ack), .cap(cap),
        .count(count), .last_slot(last_slot)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT, ST_IDLE: if (start_ok) state_nx = ST_FETCH;
            ST_FETCH: if (mem_ack && widx == WIW'(3)) state_nx = ST_EVAL;
            ST_EVAL: begin
                if (owned)          state_nx = ST_HALT;
                else if (cap == '0) state_nx = ST_STAT;
                else                state_nx = ST_DATA;
            end
            ST_DATA:  if (accept) state_nx = ST_STORE;
            ST_STORE: if (mem_ack) begin
                if (last_q)         state_nx = ST_APP;
                else if (last_slot) state_nx = ST_STAT;
                else                state_nx = ST_DATA;
            end
            ST_APP:  if (mem_ack && widx == WIW'(APP_WORDS - 1)) state_nx = ST_STAT;
            ST_STAT: if (mem_ack) state_nx = ST_NEXT;
            ST_NEXT: state_nx = (cur == tail_ptr) ? ST_IDLE : ST_FETCH;
            default: state_nx = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0; nxt_ptr <= '0; buf_ptr <= '0; cap <= '0; owned <= 1'b0;
            widx <= '0; byte_q <= '0; last_q <= 1'b0;
            sof_pend <= 1'b1; sop_here <= 1'b0; eop_q <= 1'b0;
        end else begin
            if ((state == ST_HALT || state == ST_IDLE) && start_ok) begin
                cur <= head_ptr; widx <= '0; sof_pend <= 1'b1; eop_q <= 1'b0;
            end
            if (state == ST_FETCH && mem_ack) begin
                unique case (widx[1:0])
                    2'd0: nxt_ptr <= mem_rdata[AW-1:0];
                    2'd1: buf_ptr <= mem_rdata[AW-1:0];
                    2'd2: cap     <= mem_rdata[LW-1:0];
                    default: owned <= mem_rdata[BIT_DONE];
                endcase
                widx <= widx + WIW'(1);
            end
            if (state == ST_EVAL) sop_here <= 1'b0;
            if (accept) begin
                byte_q <= s_data; last_q <= s_last;
            end
            if (state == ST_STORE && mem_ack) begin
                if (sof_pend) begin
                    sop_here <= 1'b1; sof_pend <= 1'b0;
                end
                if (last_q) begin
                    eop_q <= 1'b1; widx <= '0;
                end
            end
            if (state == ST_APP && mem_ack) widx <= widx + WIW'(1);
            if (state == ST_STAT && mem_ack && eop_q) sof_pend <= 1'b1;
            if (state == ST_NEXT) begin
                eop_q <= 1'b0;
                if (cur != tail_ptr) begin
                    cur <= nxt_ptr; widx <= '0;
                end
            end
        end
    end

    always_comb begin
        stat_word           = '0;
        stat_word[BIT_DONE] = 1'b1;
        stat_word[BIT_SOP]  = sop_here;
        stat_word[BIT_EOP]  = eop_q;
        stat_word[LW-1:0]   = count;
    end

    // outputs
    always_comb begin
        mem_req = 1'b0; mem_we = 1'b0; mem_byte = 1'b0;
        mem_addr = cur; mem_wdata = '0;
        s_ready = 1'b0; pkt_done = 1'b0; halted = 1'b0; idle = 1'b0;
        unique case (state)
            ST_HALT: halted = 1'b1;
            ST_IDLE: idle = 1'b1;
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur + (AW'(widx) << 2);
            end
            ST_EVAL: ;
            ST_DATA: s_ready = run;
            ST_STORE: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_byte = 1'b1;
                mem_addr  = buf_ptr + AW'(count);
                mem_wdata = {24'b0, byte_q};
            end
            ST_APP: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr  = cur + AW'(OFS_APP) + (AW'(widx) << 2);
                mem_wdata = app_word;
            end
            ST_STAT: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr  = cur + AW'(OFS_STAT);
                mem_wdata = stat_word;
            end
            ST_NEXT: pkt_done = eop_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/s2m_scatter_chk.sv
module s2m_scatter_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          s_ready,
    input logic          c_valid,
    input logic          c_last,
    input logic          c_err,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic [31:0]   mem_rdata,
    input logic          pkt_done,
    input logic          halted,
    input logic          idle
);
    p_ready_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (run && !idle && !halted));

    p_halt_on_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> ($past(mem_ack, 2) && $past(mem_rdata[31], 2)));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    p_stop_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle && halted));

    p_err_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        c_err |-> $past(c_valid && c_last));

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind s2m_scatter s2m_scatter_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .s_ready(s_ready),
    .c_valid(c_valid), .c_last(c_last), .c_err(c_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .pkt_done(pkt_done), .halted(halted), .idle(idle)
);

// File: tb/s2m_scatter_bench.sv
`timescale 1ns/1ps
module s2m_scatter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0, kick = 1'b0;
    logic [31:0] head_ptr = '0, tail_ptr = '0;
    logic        s_valid = 1'b0, s_last = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready;
    logic        c_valid = 1'b0, c_last = 1'b0;
    logic [31:0] c_data = '0;
    logic        c_err;
    logic        mem_req, mem_we, mem_byte;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        pkt_done, halted, idle;

    int vectors = 0, fails = 0, pkt_cnt = 0, stall_cnt = 0;
    logic [7:0]  mem [1024];
    logic [41:0] exp_q [$];
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;

    always #10 clk = ~clk;

    s2m_scatter u_s2m_scatter (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd32(input logic [9:0] a);
        return {mem[a + 10'd3], mem[a + 10'd2], mem[a + 10'd1], mem[a]};
    endfunction

    task automatic wr32(input logic [9:0] a, input logic [31:0] v);
        {mem[a + 10'd3], mem[a + 10'd2], mem[a + 10'd1], mem[a]} = v;
    endtask

    task automatic put_desc(input logic [9:0] a, input logic [31:0] nx,
                            input logic [31:0] bufa, input logic [31:0] ctl,
                            input logic [31:0] st);
        wr32(a, nx); wr32(a + 10'd4, bufa); wr32(a + 10'd8, ctl); wr32(a + 10'd12, st);
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        logic       ack_now;
        logic [9:0] a;
        a = mem_addr[9:0];
        if (pend) chk("R10 held address", {31'b0, mem_req} ^ {mem_addr} ^ pend_addr ^ 32'd1, 32'd0);
        stall_cnt = (stall_cnt == 2) ? 0 : stall_cnt + 1;
        ack_now = mem_req && (stall_cnt != 0);
        pend = mem_req && !ack_now;
        pend_addr = mem_addr;
        if (ack_now) begin
            if (mem_we) begin
                if (mem_byte) mem[a] = mem_wdata[7:0];
                else begin
                    wr32(a, mem_wdata);
                    if (a[5:0] == 6'd12) begin
                        if (exp_q.size() == 0) chk("R5 unexpected status write", {22'b0, a}, 32'hffff_ffff);
                        else begin
                            logic [41:0] e;
                            e = exp_q.pop_front();
                            chk("R5/R3 status address", {22'b0, a}, {22'b0, e[41:32]});
                            chk("R5/R3/R4 status word", mem_wdata, e[31:0]);
                        end
                    end
                end
            end else mem_rdata = rd32(a);
        end
        mem_ack = ack_now;
        if (pkt_done) pkt_cnt++;
    end

    task automatic send_ctl(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            c_valid = 1'b1; c_data = base + i; c_last = (i == n - 1);
            @(negedge clk);
        end
        c_valid = 1'b0; c_last = 1'b0;
    endtask

    task automatic send_pkt(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            logic fire;
            s_valid = 1'b1; s_data = base + 8'(i); s_last = (i == n - 1);
            fire = s_ready;
            while (!fire) begin
                @(negedge clk);
                fire = s_ready;
            end
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic do_kick(input logic [31:0] h, input logic [31:0] t);
        head_ptr = h; tail_ptr = t; kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    // which: 0 = s_ready, 1 = idle, 2 = halted
    task automatic wait_for(input int which);
        for (int i = 0; i < 300; i++) begin
            if ((which == 0 && s_ready) || (which == 1 && idle) || (which == 2 && halted)) break;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset s_ready", {31'b0, s_ready}, 32'd0);
        chk("R2 reset halted", {31'b0, halted}, 32'd1);
        chk("R7 reset idle", {31'b0, idle}, 32'd0);
        chk("R10 reset mem_req", {31'b0, mem_req}, 32'd0);

        send_ctl(5, 32'hA000_0000);
        chk("R8 five words no error", {31'b0, c_err}, 32'd0);
        send_ctl(3, 32'hE000_0000);
        chk("R8 short packet error", {31'b0, c_err}, 32'd1);
        @(negedge clk);
        chk("R8 error is one pulse", {31'b0, c_err}, 32'd0);
        send_ctl(6, 32'hD000_0000);
        chk("R8 long packet error", {31'b0, c_err}, 32'd1);

        put_desc(10'h000, 32'h40, 32'h200, 32'd4, 32'd0);
        put_desc(10'h040, 32'h80, 32'h240, 32'd4, 32'd0);
        put_desc(10'h080, 32'hC0, 32'h280, 32'd8, 32'd0);
        put_desc(10'h0C0, 32'h100, 32'h2C0, 32'd8, 32'd0);
        put_desc(10'h100, 32'h140, 32'h380, 32'd4, 32'h8000_0000);
        put_desc(10'h140, 32'h180, 32'h300, 32'd16, 32'd0);
        exp_q.push_back({10'h00C, 32'h8800_0004});
        exp_q.push_back({10'h04C, 32'h8400_0002});
        exp_q.push_back({10'h08C, 32'h8C00_0008});

        run = 1'b1;
        do_kick(32'h0, 32'hC0);
        wait_for(0);
        send_pkt(6, 8'h10);
        send_pkt(8, 8'h30);
        for (int i = 0; i < 300 && pkt_cnt < 2; i++) @(negedge clk);
        wait_for(0);
        send_ctl(5, 32'hB000_0000);
        chk("R8 second good packet", {31'b0, c_err}, 32'd0);
        exp_q.push_back({10'h0CC, 32'h8C00_0003});
        send_pkt(3, 8'h50);
        wait_for(1);
        chk("R7 idle after tail", {31'b0, idle}, 32'd1);
        chk("R7 not halted at tail", {31'b0, halted}, 32'd0);
        chk("R9 not ready when idle", {31'b0, s_ready}, 32'd0);
        chk("R1 first desc bytes", rd32(10'h200), 32'h1312_1110);
        chk("R1 partial desc bytes", rd32(10'h240), 32'h0000_1514);
        chk("R1 exact fill bytes", rd32(10'h284), 32'h3736_3534);
        chk("R1 short packet bytes", rd32(10'h2C0), 32'h0052_5150);
        chk("R4 no app on first desc", rd32(10'h010), 32'd0);
        chk("R4 app word0 on final desc", rd32(10'h050), 32'hA000_0000);
        chk("R4/R8 app word4 after bad packets", rd32(10'h060), 32'hA000_0004);
        chk("R8 updated app words", rd32(10'h0D8), 32'hB000_0002);
        chk("R6 packets completed", pkt_cnt, 32'd3);

        do_kick(32'h100, 32'h100);
        wait_for(2);
        chk("R2 halted on owned desc", {31'b0, halted}, 32'd1);
        s_valid = 1'b1; s_data = 8'h99;
        repeat (8) @(negedge clk);
        chk("R2 not ready when halted", {31'b0, s_ready}, 32'd0);
        s_valid = 1'b0;
        chk("R2 no byte stored", {24'b0, mem[10'h380]}, 32'd0);
        chk("R2 owned status untouched", rd32(10'h10C), 32'h8000_0000);

        do_kick(32'h140, 32'h140);
        wait_for(0);
        run = 1'b0;
        @(negedge clk);
        chk("R9 not ready when stopped", {31'b0, s_ready}, 32'd0);
        run = 1'b1;
        @(negedge clk);
        chk("R9 ready when running", {31'b0, s_ready}, 32'd1);
        exp_q.push_back({10'h14C, 32'h8C00_0002});
        send_pkt(2, 8'h70);
        wait_for(1);
        chk("R1 restart bytes", rd32(10'h300), 32'h0000_7170);
        chk("R4 app word0 restart", rd32(10'h150), 32'hB000_0000);
        chk("R6 total packets", pkt_cnt, 32'd4);
        chk("R5 all statuses seen", exp_q.size(), 32'd0);
        summary();
        $finish;
    end
endmodule